// File: doc/BRIEF.md
# Timer Counter Clock-Mode Selector

This block is the counting core of a general-purpose timer. A two-bit mode code decides what advances a 16-bit counter: nothing, every tick of the counter clock, rising edges on an external clock pin, or rising edges on an external trigger line. The pin and the trigger are not used directly. Each first passes through a two-flop synchronizer clocked by the counter clock, then through a rising-edge detector that gives a single-cycle count enable. This is why an external source has to run at less than half the counter clock rate, and why each of its levels must last at least two counter clocks.

The mode code is written from a register-interface clock domain. Every accepted write crosses into the counter domain through a toggle request and comes back through a toggle acknowledgement. A non-zero code appears on the readback as soon as it is written. A zero code, which stops the counter, appears on the readback only after the counter domain has acknowledged it. While a crossing is in flight the block reports busy and ignores further writes.

The counter runs from 0 up to a programmable modulo value, then returns to 0 and raises a one-cycle wrap pulse. Stopping the counter keeps its value.

Top module: `timer_clk_core`

## Requirements
- R1: After reset the count is 0, the readback `rd_mode` is 00, and `busy` and `wrap` are low. With mode 00 no input moves the count.
- R2: The mode codes are 00 stopped, 01 counter clock, 10 external pin, 11 external trigger. In mode 01 the count rises by exactly one on every counter-clock edge.
- R3: In mode 00 the count holds. Writing 00 stops counting and keeps the count value that was reached.
- R4: After a write of 00, `rd_mode` keeps the previous code while `busy` is high, and reads 00 once `busy` falls.
- R5: A write of a non-zero code shows on `rd_mode` on the first register-clock edge after the write.
- R6: In mode 10 the count rises by one for each rising edge of `ext_pin` that is held at least two counter clocks per level. `ext_trig` has no effect.
- R7: In mode 11 the count rises by one for each rising edge of `ext_trig` that is held at least two counter clocks per level. `ext_pin` has no effect.
- R8: A write made while `busy` is high is dropped. Both the readback and the active source stay as the earlier write set them.
- R9: When an increment finds the count equal to `modulo`, the count becomes 0 and `wrap` is high for that one cycle. In no other cycle is `wrap` high.
- R10: `busy` goes high on the edge that accepts a write. It falls only after the acknowledgement has returned from the counter domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| reg_clk | input | 1 | Register-interface clock |
| reg_rst_n | input | 1 | Active-low asynchronous reset, register domain |
| wr_en | input | 1 | Write strobe for the mode code |
| wr_mode | input | 2 | Mode code to write |
| rd_mode | output | 2 | Mode code readback |
| busy | output | 1 | A mode crossing is in flight and writes are ignored |
| cnt_clk | input | 1 | Counter clock |
| cnt_rst_n | input | 1 | Active-low asynchronous reset, counter domain |
| ext_pin | input | 1 | External clock pin, asynchronous |
| ext_trig | input | 1 | External trigger line, asynchronous |
| modulo | input | 16 | Terminal count before the counter returns to 0 |
| count | output | 16 | Counter value |
| wrap | output | 1 | One-cycle pulse when the count returns to 0 |

## Verification
The bench targets five corner cases.

- **Stop readback timing.** It checks that a stop write does not show on the readback early. A design that cleared the readback at once would report 00 while the counter was still running.
- **Preserved count.** It checks that the count survives a stop. A design that cleared the count on disable would restart from zero.
- **Source isolation.** It drives the unselected source while the other mode is active. A design with a wrong source mux would count edges it should ignore.
- **Write rejection.** It fires a second write while `busy` is high. A design that accepted it could change the staged code during the crossing and end up with a source that does not match the readback.
- **Wrap at modulo.** It counts wrap pulses against a small modulo. A design with an off-by-one terminal compare would change the wrap period.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_TICK = 2'b01,
        MODE_PIN  = 2'b10,
        MODE_TRIG = 2'b11
    } mode_e;
endpackage

// File: rtl/tcc_sync.sv
module tcc_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_q [STAGES];
    logic [W-1:0] stg_d [STAGES];

    always_comb begin
        stg_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= '0;
                else        stg_q[g] <= stg_d[g];
            end
        end
    endgenerate

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/tcc_edge.sv
module tcc_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic sync_s;
    logic prev_d, prev_q;

    tcc_sync #(.W(1), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (async_in),
        .q     (sync_s)
    );

    always_comb begin
        prev_d = sync_s;
        rise   = sync_s & ~prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    AST_EDGE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R6
endmodule

// File: rtl/tcc_reg_side.sv
module tcc_reg_side
    import tcc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  mode_e wr_mode,
    input  logic  ack_s,
    output mode_e rd_mode,
    output mode_e stage_mode,
    output logic  req_tgl,
    output logic  busy
);
    typedef struct packed {
        mode_e rd;
        mode_e stage;
        logic  pend;
        logic  req;
    } rstate_t;

    rstate_t q, d;

    always_comb begin
        d = q;
        if (q.pend && (ack_s == q.req)) begin
            d.pend = 1'b0;
            if (q.stage == MODE_OFF) d.rd = MODE_OFF;
        end
        if (wr_en && !q.pend) begin
            d.stage = wr_mode;
            d.req   = ~q.req;
            d.pend  = 1'b1;
            if (wr_mode != MODE_OFF) d.rd = wr_mode;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{rd: MODE_OFF, stage: MODE_OFF, pend: 1'b0, req: 1'b0};
        else        q <= d;
    end

    assign rd_mode    = q.rd;
    assign stage_mode = q.stage;
    assign req_tgl    = q.req;
    assign busy       = q.pend;

    AST_REJECT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (q.pend && wr_en) |=> $stable(q.req) && $stable(q.stage)); // R8
    AST_BUSY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !q.pend) |=> q.pend); // R10
    AST_OFF_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.rd == MODE_OFF) && ($past(q.rd) != MODE_OFF)) |-> ($past(q.pend) && !q.pend)); // R4
endmodule

// File: rtl/tcc_cnt_side.sv
module tcc_cnt_side
    import tcc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_s,
    input  mode_e            stage_mode,
    input  logic             pin_rise,
    input  logic             trig_rise,
    input  logic [CNT_W-1:0] modulo,
    output logic [CNT_W-1:0] count,
    output logic             wrap,
    output logic             ack_tgl
);
    typedef struct packed {
        mode_e            act;
        logic             ack;
        logic [CNT_W-1:0] cnt;
        logic             wrap;
    } cstate_t;

    cstate_t q, d;
    logic    inc;

    always_comb begin
        d      = q;
        d.wrap = 1'b0;
        if (req_s != q.ack) begin
            d.act = stage_mode;
            d.ack = req_s;
        end
        unique case (q.act)
            MODE_TICK: inc = 1'b1;
            MODE_PIN:  inc = pin_rise;
            MODE_TRIG: inc = trig_rise;
            default:   inc = 1'b0;
        endcase
        if (inc) begin
            if (q.cnt == modulo) begin
                d.cnt  = '0;
                d.wrap = 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{act: MODE_OFF, ack: 1'b0, cnt: '0, wrap: 1'b0};
        else        q <= d;
    end

    assign count   = q.cnt;
    assign wrap    = q.wrap;
    assign ack_tgl = q.ack;

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (q.act == MODE_OFF) |=> $stable(q.cnt)); // R3
    AST_STEP_OR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.cnt) |-> ((q.cnt == CNT_W'($past(q.cnt) + 1'b1)) || (q.cnt == '0))); // R2
    AST_WRAP_AT_MOD: assert property (@(posedge clk) disable iff (!rst_n)
        q.wrap |-> ((q.cnt == '0) && ($past(q.cnt) == $past(modulo)))); // R9
endmodule

// File: rtl/timer_clk_core.sv
module timer_clk_core
    import tcc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             reg_clk,
    input  logic             reg_rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_mode,
    output logic [1:0]       rd_mode,
    output logic             busy,
    input  logic             cnt_clk,
    input  logic             cnt_rst_n,
    input  logic             ext_pin,
    input  logic             ext_trig,
    input  logic [CNT_W-1:0] modulo,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    mode_e rd_m, stage_m;
    logic  req_tgl, req_s, ack_tgl, ack_s;
    logic  pin_rise, trig_rise;

    tcc_reg_side u_reg (
        .clk        (reg_clk),
        .rst_n      (reg_rst_n),
        .wr_en      (wr_en),
        .wr_mode    (mode_e'(wr_mode)),
        .ack_s      (ack_s),
        .rd_mode    (rd_m),
        .stage_mode (stage_m),
        .req_tgl    (req_tgl),
        .busy       (busy)
    );

    tcc_sync #(.W(1), .STAGES(SYNC_STAGES)) u_req_sync (
        .clk   (cnt_clk),
        .rst_n (cnt_rst_n),
        .d     (req_tgl),
        .q     (req_s)
    );

    tcc_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ack_sync (
        .clk   (reg_clk),
        .rst_n (reg_rst_n),
        .d     (ack_tgl),
        .q     (ack_s)
    );

    tcc_edge #(.SYNC_STAGES(SYNC_STAGES)) u_pin_edge (
        .clk      (cnt_clk),
        .rst_n    (cnt_rst_n),
        .async_in (ext_pin),
        .rise     (pin_rise)
    );

    tcc_edge #(.SYNC_STAGES(SYNC_STAGES)) u_trig_edge (
        .clk      (cnt_clk),
        .rst_n    (cnt_rst_n),
        .async_in (ext_trig),
        .rise     (trig_rise)
    );

    tcc_cnt_side #(.CNT_W(CNT_W)) u_cnt (
        .clk        (cnt_clk),
        .rst_n      (cnt_rst_n),
        .req_s      (req_s),
        .stage_mode (stage_m),
        .pin_rise   (pin_rise),
        .trig_rise  (trig_rise),
        .modulo     (modulo),
        .count      (count),
        .wrap       (wrap),
        .ack_tgl    (ack_tgl)
    );

    assign rd_mode = rd_m;
endmodule

// File: tb/timer_clk_core_test.sv
module timer_clk_core_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_mode = 2'b00;
    logic [1:0]  rd_mode;
    logic        busy;
    logic        ext_pin = 1'b0;
    logic        ext_trig = 1'b0;
    logic [15:0] modulo = 16'hFFFF;
    logic [15:0] count;
    logic        wrap;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    timer_clk_core uut (
        .reg_clk   (clk),
        .reg_rst_n (rst_n),
        .wr_en     (wr_en),
        .wr_mode   (wr_mode),
        .rd_mode   (rd_mode),
        .busy      (busy),
        .cnt_clk   (clk),
        .cnt_rst_n (rst_n),
        .ext_pin   (ext_pin),
        .ext_trig  (ext_trig),
        .modulo    (modulo),
        .count     (count),
        .wrap      (wrap)
    );

    typedef struct packed {
        logic [1:0] m;
        logic [3:0] npin;
        logic [3:0] ntrig;
        logic [3:0] exp;
    } vec_t;

    localparam vec_t VEC [5] = '{
        '{m: 2'b10, npin: 4'd3, ntrig: 4'd2, exp: 4'd3},
        '{m: 2'b11, npin: 4'd3, ntrig: 4'd2, exp: 4'd2},
        '{m: 2'b10, npin: 4'd0, ntrig: 4'd4, exp: 4'd0},
        '{m: 2'b11, npin: 4'd5, ntrig: 4'd0, exp: 4'd0},
        '{m: 2'b10, npin: 4'd4, ntrig: 4'd4, exp: 4'd4}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [1:0] m);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_mode = m;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 50 && busy; i++) @(negedge clk);
    endtask

    task automatic pulse_pin(input int n);
        for (int i = 0; i < n; i++) begin
            ext_pin = 1'b1;
            repeat (3) @(negedge clk);
            ext_pin = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic pulse_trig(input int n);
        for (int i = 0; i < n; i++) begin
            ext_trig = 1'b1;
            repeat (3) @(negedge clk);
            ext_trig = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #500000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] snap;
        int          wraps;
        do_reset();

        // R1 reset state
        check(count == 16'd0, "R1 count", count, 0);
        check(rd_mode == 2'b00, "R1 rd_mode", rd_mode, 0);
        check(!busy, "R1 busy", busy, 0);
        check(!wrap, "R1 wrap", wrap, 0);
        pulse_pin(2);
        pulse_trig(2);
        check(count == 16'd0, "R1 idle after pulses", count, 0);

        // R5 / R10 enable mode 01
        do_write(2'b01);
        check(rd_mode == 2'b01, "R5 readback at once", rd_mode, 1);
        check(busy, "R10 busy after write", busy, 1);
        wait_idle();
        check(!busy, "R10 busy clears", busy, 0);
        snap = count;
        repeat (20) @(negedge clk);
        check(count == snap + 16'd20, "R2 tick count", count, snap + 16'd20);

        // R4 / R3 disable
        do_write(2'b00);
        check(rd_mode == 2'b01, "R4 readback before ack", rd_mode, 1);
        check(busy, "R4 busy during stop", busy, 1);
        wait_idle();
        check(rd_mode == 2'b00, "R4 readback after ack", rd_mode, 0);
        snap = count;
        repeat (20) @(negedge clk);
        check(count == snap, "R3 count holds", count, snap);
        check(snap >= 16'd20, "R3 value kept", snap, 20);

        // R6 / R7 vector table
        foreach (VEC[k]) begin
            do_write(VEC[k].m);
            wait_idle();
            repeat (4) @(negedge clk);
            snap = count;
            pulse_pin(int'(VEC[k].npin));
            pulse_trig(int'(VEC[k].ntrig));
            repeat (8) @(negedge clk);
            check(count == snap + 16'(VEC[k].exp),
                  (VEC[k].m == 2'b10) ? "R6 pin vector" : "R7 trig vector",
                  count - snap, VEC[k].exp);
        end

        // R8 write while busy ignored
        do_write(2'b10);
        do_write(2'b11);
        wait_idle();
        repeat (4) @(negedge clk);
        check(rd_mode == 2'b10, "R8 readback kept", rd_mode, 2);
        snap = count;
        pulse_trig(2);
        repeat (8) @(negedge clk);
        check(count == snap, "R8 trig ignored", count - snap, 0);
        pulse_pin(2);
        repeat (8) @(negedge clk);
        check(count == snap + 16'd2, "R8 pin source kept", count - snap, 2);

        // R9 wrap at modulo
        do_reset();
        modulo = 16'd5;
        do_write(2'b01);
        wait_idle();
        wraps = 0;
        for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            check(count <= 16'd5, "R9 count bounded", count, 5);
            if (wrap) begin
                wraps++;
                check(count == 16'd0, "R9 zero on wrap", count, 0);
            end
        end
        check(wraps == 4, "R9 wrap count", wraps, 4);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule